// File: doc/BRIEF.md
# Chopping Current Controller with Loop Select

This block decides, cycle by cycle, whether the single high-side switch of a unipolar stepper driver is on. A free-running period counter stands in for the RC oscillator. Each time it wraps, it sets a set/reset flip-flop, and the flip-flop's output is the gate enable of the high-side switch. Two mechanisms can end the on-time, and a mode input picks between them.

In closed-loop mode a digital flag from the external current comparator clears the flip-flop, which holds the winding current near the reference. In this mode one configuration bit selects a full or a halved chopping period. In open-loop mode the comparator plays no part. A fixed on-time, picked by a two-bit duty code, clears the flip-flop, and the period always stays at its full length.

A phase-change strobe restarts the period, sets the switch at once, and produces a one-cycle sync pulse. Inhibit and thermal-fault inputs force the switch off. The synchronous reset clears all state.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst_n` is low, `hs_gate` and `sync_pulse` are 0 at the next edge, and the period counter restarts from zero.
- R2: `hs_gate` goes high only at the edge that follows a period wrap or a `phase_strobe`. In open-loop mode the period between set events is `PERIOD` cycles.
- R3: In closed-loop mode (`loop_open`=0), a high `cmp_trip` drives `hs_gate` low at the next edge. The gate therefore stays high for exactly as many cycles as the comparator takes to trip.
- R4: In closed-loop mode, `half_rate`=0 gives a period of `PERIOD` cycles and `half_rate`=1 gives `PERIOD/2` cycles. In open-loop mode `half_rate` has no effect.
- R5: In open-loop mode, the on-time for `duty_sel` 0, 1, 2 and 3 is 2/8, 4/8, 6/8 and 7/8 of `PERIOD`. `cmp_trip` has no effect in this mode.
- R6: A `phase_strobe` restarts the period count from zero and sets `hs_gate` at the next edge, unless a clear or a fault is present.
- R7: `sync_pulse` is high for exactly the cycles that follow a cycle with `phase_strobe` high, and low otherwise.
- R8: When a clear and a set happen in the same cycle, the clear wins. With `cmp_trip` held high in closed-loop mode, the switch stays off for the whole period.
- R9: A high `inhibit` or `therm_fault` drives `hs_gate` low at the next edge and keeps it low. After the fault is released, the gate turns on again only at the next set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_open | input | 1 | 0 = closed loop (comparator), 1 = open loop (fixed on-time) |
| half_rate | input | 1 | Closed loop only: 1 halves the chopping period |
| duty_sel | input | 2 | Open loop only: on-time code |
| cmp_trip | input | 1 | Sense level has reached the reference |
| phase_strobe | input | 1 | Phase change event |
| inhibit | input | 1 | Forces the switch off |
| therm_fault | input | 1 | Over-temperature, forces the switch off |
| hs_gate | output | 1 | High-side switch gate enable |
| sync_pulse | output | 1 | One-cycle pulse after a phase change |

## Verification
Every result of this block sits one register away from its cause. A set, a clear, a fault, a strobe or a reset changes `hs_gate` or `sync_pulse` at the very next rising edge. The bench drives its inputs on falling edges and samples on the following falling edge, so each check lands half a cycle after the edge that should have produced the result. On-times and periods are measured by counting samples from the first high sample after a strobe, and the closed-loop comparator model trips once it has seen a chosen number of high samples. The expected on-time is therefore that number, and the expected period is `PERIOD` or `PERIOD/2`.

// File: rtl/chop_pkg.sv
// Package: shared types and helpers for the chopping controller.
// Assumes PERIOD is a multiple of 8 so the duty fractions are exact.
package chop_pkg;

    typedef enum logic {
        LOOP_CLOSED = 1'b0,
        LOOP_OPEN   = 1'b1
    } loop_mode_e;

    // On-time in eighths of the period for each open-loop duty code.
    function automatic int unsigned duty_eighths(input logic [1:0] code);
        case (code)
            2'd0:    duty_eighths = 2;
            2'd1:    duty_eighths = 4;
            2'd2:    duty_eighths = 6;
            default: duty_eighths = 7;
        endcase
    endfunction

endpackage

// File: rtl/chop_period_gen.sv
// Module: period counter that models the chopping oscillator.
// Counts 0..last and flags a tick on the final count. A restart input
// forces the count back to zero. If the length shrinks while the count
// is already past the new end, the count wraps at once.
module chop_period_gen #(
    parameter int unsigned PERIOD = 64,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          half_sel,
    output logic [CW-1:0] cnt,
    output logic          tick
);

    localparam logic [CW-1:0] LAST_FULL = CW'(PERIOD - 1);
    localparam logic [CW-1:0] LAST_HALF = CW'(PERIOD / 2 - 1);

    logic [CW-1:0] last;

    // Pick the final count for the active period length.
    always_comb begin
        last = half_sel ? LAST_HALF : LAST_FULL;
        tick = (cnt >= last);
    end

    // Advance, wrap or restart the period count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/chop_ontime.sv
// Module: fixed on-time end detector for open-loop chopping.
// Flags the last on-cycle of the period for the selected duty code.
// The flag is held off in a cycle in which the period restarts, so a
// restart that lands on the end count still opens a new on-time.
module chop_ontime #(
    parameter int unsigned PERIOD = 64,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    duty_sel,
    input  logic          restart,
    output logic          end_ev
);

    import chop_pkg::*;

    logic [CW-1:0] end_cnt [4];

    // One end-count constant per duty code, computed from PERIOD.
    for (genvar g = 0; g < 4; g++) begin : g_end
        assign end_cnt[g] = CW'((PERIOD / 8) * duty_eighths(2'(g)) - 1);
    end

    // Compare against the selected end count.
    always_comb begin
        end_ev = (cnt == end_cnt[duty_sel]) && !restart;
    end

endmodule

// File: rtl/chop_switch_ff.sv
// Module: set/reset flip-flop that drives the high-side gate.
// Priority, highest first: kill, then clear, then set. Assumes all
// inputs are synchronous to clk.
module chop_switch_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic kill,
    output logic gate
);

    // Update the switch state with clear and kill winning over set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate <= 1'b0;
        else if (kill || clr_ev)
            gate <= 1'b0;
        else if (set_ev)
            gate <= 1'b1;
    end

endmodule

// File: rtl/chop_ctrl.sv
// Module: chopping controller top. A period wrap or a phase strobe sets
// the switch. The comparator (closed loop) or the fixed on-time (open
// loop) clears it. Inhibit and thermal fault force it off. Assumes
// PERIOD >= 16 and is a multiple of 8.
module chop_ctrl #(
    parameter int unsigned PERIOD = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_open,
    input  logic       half_rate,
    input  logic [1:0] duty_sel,
    input  logic       cmp_trip,
    input  logic       phase_strobe,
    input  logic       inhibit,
    input  logic       therm_fault,
    output logic       hs_gate,
    output logic       sync_pulse
);

    import chop_pkg::*;

    localparam int unsigned CW = $clog2(PERIOD);

    loop_mode_e    mode;
    logic [CW-1:0] per_cnt;
    logic          per_tick;
    logic          half_sel;
    logic          ot_end;
    logic          set_ev;
    logic          clr_ev;
    logic          kill;

    // Decode the mode and form the set, clear and kill events.
    always_comb begin
        mode     = loop_open ? LOOP_OPEN : LOOP_CLOSED;
        half_sel = (mode == LOOP_CLOSED) && half_rate;
        set_ev   = per_tick || phase_strobe;
        clr_ev   = (mode == LOOP_OPEN) ? ot_end : cmp_trip;
        kill     = inhibit || therm_fault;
    end

    chop_period_gen #(.PERIOD(PERIOD)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (phase_strobe),
        .half_sel (half_sel),
        .cnt      (per_cnt),
        .tick     (per_tick)
    );

    chop_ontime #(.PERIOD(PERIOD)) u_ot (
        .cnt      (per_cnt),
        .duty_sel (duty_sel),
        .restart  (phase_strobe),
        .end_ev   (ot_end)
    );

    chop_switch_ff u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr_ev (clr_ev),
        .kill   (kill),
        .gate   (hs_gate)
    );

    // Register the phase strobe into a one-cycle sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_pulse <= 1'b0;
        else
            sync_pulse <= phase_strobe;
    end

endmodule

// File: rtl/chop_ctrl_chk.sv
// Module: assertion checker for chop_ctrl, attached with bind.
module chop_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic loop_open,
    input logic cmp_trip,
    input logic phase_strobe,
    input logic inhibit,
    input logic therm_fault,
    input logic hs_gate,
    input logic sync_pulse,
    input logic per_tick
);

    // R1: reset clears the outputs at the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!hs_gate && !sync_pulse));

    // R2: the gate rises only after a period wrap or a strobe.
    a_r2_rise_after_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(per_tick || phase_strobe));

    // R3 and R8: a closed-loop trip wins and turns the switch off.
    a_r3_trip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_open && cmp_trip) |=> !hs_gate);

    // R6: a strobe without a clear or a fault turns the switch on.
    a_r6_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_strobe && !inhibit && !therm_fault && (loop_open || !cmp_trip))
        |=> hs_gate);

    // R7: the sync pulse follows the strobe by one cycle.
    a_r7_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
        phase_strobe |=> sync_pulse);

    // R7: no sync pulse without a strobe.
    a_r7_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_strobe |=> !sync_pulse);

    // R9: a fault forces the switch off.
    a_r9_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit || therm_fault) |=> !hs_gate);

endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop_open    (loop_open),
    .cmp_trip     (cmp_trip),
    .phase_strobe (phase_strobe),
    .inhibit      (inhibit),
    .therm_fault  (therm_fault),
    .hs_gate      (hs_gate),
    .sync_pulse   (sync_pulse),
    .per_tick     (per_tick)
);

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;

    localparam int unsigned PERIOD = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_open = 1'b0;
    logic       half_rate = 1'b0;
    logic [1:0] duty_sel = 2'd0;
    logic       cmp_trip = 1'b0;
    logic       phase_strobe = 1'b0;
    logic       inhibit = 1'b0;
    logic       therm_fault = 1'b0;
    logic       hs_gate;
    logic       sync_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    chop_ctrl #(.PERIOD(PERIOD)) dut (
        .clk(clk), .rst_n(rst_n), .loop_open(loop_open), .half_rate(half_rate),
        .duty_sel(duty_sel), .cmp_trip(cmp_trip), .phase_strobe(phase_strobe),
        .inhibit(inhibit), .therm_fault(therm_fault),
        .hs_gate(hs_gate), .sync_pulse(sync_pulse)
    );

    // Vector: mode, half, duty, trip count, expected on-time, expected period.
    typedef struct packed {
        logic       open;
        logic       half;
        logic [1:0] duty;
        logic [7:0] k;
        logic [7:0] exp_hi;
        logic [7:0] exp_tot;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 2'd0, 8'd10, 8'd10, 8'd64, 8'd3},
        '{1'b0, 1'b1, 2'd0, 8'd10, 8'd10, 8'd32, 8'd4},
        '{1'b0, 1'b0, 2'd3, 8'd40, 8'd40, 8'd64, 8'd3},
        '{1'b0, 1'b1, 2'd2, 8'd20, 8'd20, 8'd32, 8'd4},
        '{1'b1, 1'b0, 2'd0, 8'd5,  8'd16, 8'd64, 8'd5},
        '{1'b1, 1'b0, 2'd1, 8'd5,  8'd32, 8'd64, 8'd5},
        '{1'b1, 1'b0, 2'd2, 8'd5,  8'd48, 8'd64, 8'd5},
        '{1'b1, 1'b1, 2'd3, 8'd5,  8'd56, 8'd64, 8'd4}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string rtag(input logic [7:0] r);
        case (r)
            8'd3:    rtag = "R3";
            8'd4:    rtag = "R4";
            default: rtag = "R5";
        endcase
    endfunction

    // Strobe once, then measure one on-time and one period.
    task automatic run_vec(input vec_t v);
        int hi;
        int tot;
        int sync_seen;
        bit low_seen;
        @(negedge clk);
        loop_open = v.open; half_rate = v.half; duty_sel = v.duty;
        cmp_trip = 1'b0; phase_strobe = 1'b1;
        @(negedge clk);
        phase_strobe = 1'b0;
        check("R7", "sync after strobe", int'(sync_pulse), 1);
        check("R6", "gate after strobe", int'(hs_gate), 1);
        hi = 0; tot = 0; sync_seen = 0; low_seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (hs_gate && low_seen) break;
            if (i > 0 && sync_pulse) sync_seen++;
            tot++;
            if (hs_gate) begin
                hi++;
                if (hi == int'(v.k)) cmp_trip = 1'b1;
            end else begin
                low_seen = 1'b1;
                cmp_trip = 1'b0;
            end
            @(negedge clk);
        end
        check(rtag(v.req), "on-time", hi, int'(v.exp_hi));
        check(v.open ? "R2" : "R4", "period", tot, int'(v.exp_tot));
        check("R7", "no extra sync", sync_seen, 0);
    endtask

    // Apply a fault mid on-time and check hold and resume.
    task automatic fault_test(input bit use_therm);
        int highs;
        bit rose;
        string tag;
        tag = "R9";
        @(negedge clk);
        loop_open = 1'b1; duty_sel = 2'd3; cmp_trip = 1'b0; phase_strobe = 1'b1;
        @(negedge clk);
        phase_strobe = 1'b0;
        repeat (3) @(negedge clk);
        if (use_therm) therm_fault = 1'b1; else inhibit = 1'b1;
        @(negedge clk);
        check(tag, use_therm ? "therm off" : "inhibit off", int'(hs_gate), 0);
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            if (hs_gate) highs++;
            @(negedge clk);
        end
        check(tag, "held off", highs, 0);
        therm_fault = 1'b0; inhibit = 1'b0;
        @(negedge clk);
        check(tag, "no resume before set", int'(hs_gate), 0);
        rose = 1'b0;
        for (int i = 0; i < PERIOD + 2; i++) begin
            if (hs_gate) begin rose = 1'b1; break; end
            @(negedge clk);
        end
        check(tag, "resume at wrap", int'(rose), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        int highs;
        repeat (4) @(negedge clk);
        // R1: reset state.
        check("R1", "gate in reset", int'(hs_gate), 0);
        check("R1", "sync in reset", int'(sync_pulse), 0);
        rst_n = 1'b1;

        foreach (VECS[i]) run_vec(VECS[i]);

        fault_test(1'b0);
        fault_test(1'b1);

        // R8: comparator high when the set arrives keeps the switch off.
        @(negedge clk);
        loop_open = 1'b0; half_rate = 1'b0; cmp_trip = 1'b1; phase_strobe = 1'b1;
        @(negedge clk);
        phase_strobe = 1'b0;
        check("R7", "sync with trip", int'(sync_pulse), 1);
        highs = 0;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            if (hs_gate) highs++;
            @(negedge clk);
        end
        check("R8", "off through trip", highs, 0);
        cmp_trip = 1'b0;

        // R1: reset during an on-time.
        @(negedge clk);
        loop_open = 1'b1; duty_sel = 2'd3; phase_strobe = 1'b1;
        @(negedge clk);
        phase_strobe = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        phase_strobe = 1'b0;
        check("R1", "gate after reset", int'(hs_gate), 0);
        check("R1", "sync after reset", int'(sync_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset the counter starts at zero, so the first wrap
        // comes PERIOD edges after release.
        highs = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (hs_gate && highs == 0) highs = i + 1;
        end
        check("R1", "first set after reset", highs, PERIOD);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule